// File: doc/BRIEF.md
# Programmable 16-bit down-counting timer

This block is a 16-bit down counter that sits behind a small byte-wide register bus. Software sets a 16-bit period through two byte registers and then writes a control byte. That byte starts or pauses the counter, picks auto-reload or single-shot operation, and chooses the count source. The source is either every system clock cycle or rising edges on an external count pin.

When the period runs out, the block sets a pending flag. The interrupt output shows that flag whenever the enable bit is set. A bus read of the control byte clears the flag, so an interrupt handler acknowledges the timer simply by reading its control state.

The bus has three addresses. Reads are combinational on `reg_rdata` while `reg_rd` is high, and a read takes effect at the clock edge that ends it. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `prog_down_timer`

## Requirements
- R1: After reset, the control byte (address 0), the low value byte (address 1) and the high value byte (address 2) all read 0x00, and `irq` is low.
- R2: Control bits 7:4 always read as zero, and writes to them have no effect. Bits 3:0 read back as written, except that bit 1 is cleared by a one-shot expiry.
- R3: Writing the control byte with bit 1 (start) set loads the counter from the 16-bit value and starts it. With the internal source selected (bit 3 = 0), the pending flag is set by the N-th clock edge after the start write, where N is the loaded value.
- R4: `irq` is high exactly when the pending flag is set and control bit 0 (interrupt enable) is 1. With the enable at 0, an expiry still sets the flag, and enabling later raises `irq`.
- R5: A read of the control byte clears the pending flag at the edge that ends the read. If an expiry falls on that same edge, the flag stays set.
- R6: With control bit 2 = 0 (retrigger), the counter reloads the 16-bit value at expiry and keeps running, so the flag is set again every N ticks.
- R7: With control bit 2 = 1 (one-shot), the counter stops after its first expiry and control bit 1 reads back as 0. No further expiry occurs.
- R8: With control bit 3 = 1, each rising edge of `ext_count_in` decrements the counter once. The edge is seen through a two-stage synchronizer and an edge detector, and a level held high counts only once. Internal clock cycles do not count in this mode.
- R9: Writing the control byte with bit 1 = 0 stops counting, so no expiry occurs while the counter is stopped.
- R10: A 16-bit value of zero gives a period of 65536 ticks.
- R11: The low byte holds value bits 7:0 and the high byte holds bits 15:8. Both bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 control, 1 low value byte, 2 high value byte |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a control read clears the pending flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| ext_count_in | input | 1 | External count input, asynchronous to clk |
| irq | output | 1 | Timer interrupt, pending flag gated by enable |

## Verification
The start write lands on edge E. With the internal source and value N, the pending flag and `irq` change after edge E+N. The bench checks that `irq` is still low at the falling edge just before E+N and high at the falling edge just after it. An external rising edge counts three system clock edges after it is driven: two synchronizer stages plus the edge register. Each external pulse is therefore held for three cycles before the bench samples. Control reads clear the flag at the edge that ends the read, so the bench samples the flag after that edge, and it places one read exactly on the expiry edge to cover the collision case.

// File: rtl/prog_down_timer.sv
module prog_down_timer #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_count_in,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(2);

  logic ien, run, oneshot, ext_sel, pend;
  logic [DATA_W-1:0] val_lo, val_hi;
  logic [CNT_W-1:0] cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic sync_prev;
  logic unused_wbits;

  logic ctl_wr, ctl_rd, ext_edge, tick, expire;
  logic [CNT_W-1:0] reload;

  assign ctl_wr   = reg_wr && reg_addr == A_CTL;
  assign ctl_rd   = reg_rd && reg_addr == A_CTL;
  assign reload   = {val_hi, val_lo};
  assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_prev;
  assign tick     = run && (ext_sel ? ext_edge : 1'b1);
  assign expire   = tick && cnt == CNT_W'(1);
  assign irq      = pend & ien;
  assign unused_wbits = ^reg_wdata[DATA_W-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      sync_prev <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], ext_count_in};
      sync_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_lo <= '0;
      val_hi <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_LO) val_lo <= reg_wdata;
      if (reg_addr == A_HI) val_hi <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= 1'b0;
      run     <= 1'b0;
      oneshot <= 1'b0;
      ext_sel <= 1'b0;
    end else if (ctl_wr) begin
      ien     <= reg_wdata[0];
      run     <= reg_wdata[1];
      oneshot <= reg_wdata[2];
      ext_sel <= reg_wdata[3];
    end else if (expire && oneshot) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (ctl_wr && reg_wdata[1]) cnt <= reload;
    else if (expire && !oneshot)    cnt <= reload;
    else if (tick)                  cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (expire) pend <= 1'b1;
    else if (ctl_rd) pend <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_CTL:   reg_rdata = DATA_W'({ext_sel, oneshot, run, ien});
        A_LO:    reg_rdata = val_lo;
        A_HI:    reg_rdata = val_hi;
        default: reg_rdata = '0;
      endcase
    end
  end

  AST_PEND_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n) expire |=> pend); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ctl_rd && !expire) |=> !pend); // R5
  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) (expire && !oneshot && !ctl_wr) |=> (cnt == $past(reload) && run)); // R6
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n) (expire && oneshot && !ctl_wr) |=> !run); // R7
  AST_EXT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (run && ext_sel && !ext_edge && !ctl_wr) |=> $stable(cnt)); // R8
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !ctl_wr) |=> $stable(cnt)); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!ien && !ctl_wr) |=> !irq); // R4
endmodule

// File: tb/sim_prog_down_timer.sv
module sim_prog_down_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ext_count_in = 1'b0;
  logic irq;
  int total = 0, bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  prog_down_timer u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_count_in(ext_count_in), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_val(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic ext_pulse();
    ext_count_in = 1'b1; cyc(3);
    ext_count_in = 1'b0; cyc(3);
  endtask

  task automatic t_reset_reserved();
    rd(2'd0, rv); chk("R1 ctl", rv, 0);
    rd(2'd1, rv); chk("R1 lo", rv, 0);
    rd(2'd2, rv); chk("R1 hi", rv, 0);
    chk("R1 irq", irq, 0);
    wr(2'd0, 8'hF4);
    rd(2'd0, rv); chk("R2 reserved", rv, 8'h04);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_byte_order();
    set_val(16'h0102);
    rd(2'd1, rv); chk("R11 lo", rv, 8'h02);
    rd(2'd2, rv); chk("R11 hi", rv, 8'h01);
    wr(2'd0, 8'h03);
    cyc(257); chk("R11 before 258", irq, 0);
    cyc(1);   chk("R11 at 258", irq, 1);
    wr(2'd0, 8'h01);
    rd(2'd0, rv); chk("R5 clear", irq, 0);
  endtask

  task automatic t_retrigger();
    set_val(16'd5);
    wr(2'd0, 8'h03);
    cyc(4); chk("R3 before N", irq, 0);
    cyc(1); chk("R3 at N", irq, 1);
    rd(2'd0, rv); chk("R5 cleared", irq, 0);
    chk("R6 still running", rv, 8'h03);
    cyc(3); chk("R6 before 2N", irq, 0);
    cyc(1); chk("R6 at 2N", irq, 1);
    wr(2'd0, 8'h01);
    rd(2'd0, rv);
  endtask

  task automatic t_collision();
    set_val(16'd4);
    wr(2'd0, 8'h03);
    cyc(4); chk("R6 first expiry", irq, 1);
    rd(2'd0, rv); chk("R5 cleared", irq, 0);
    cyc(2);
    rd(2'd0, rv); chk("R5 expiry wins over read", irq, 1);
    wr(2'd0, 8'h01);
    rd(2'd0, rv); chk("R5 later read clears", irq, 0);
  endtask

  task automatic t_mask();
    set_val(16'd3);
    wr(2'd0, 8'h02);
    cyc(6); chk("R4 masked", irq, 0);
    wr(2'd0, 8'h01); chk("R4 enable shows pending", irq, 1);
    rd(2'd0, rv); chk("R4 cleared", irq, 0);
  endtask

  task automatic t_oneshot();
    set_val(16'd3);
    wr(2'd0, 8'h07);
    cyc(2); chk("R7 before", irq, 0);
    cyc(1); chk("R7 at N", irq, 1);
    rd(2'd0, rv); chk("R7 start bit dropped", rv, 8'h05);
    cyc(12); chk("R7 no second expiry", irq, 0);
  endtask

  task automatic t_pause();
    set_val(16'd6);
    wr(2'd0, 8'h03);
    cyc(3);
    wr(2'd0, 8'h01);
    cyc(20); chk("R9 stopped no expiry", irq, 0);
    rd(2'd0, rv); chk("R9 ctl", rv, 8'h01);
  endtask

  task automatic t_external();
    set_val(16'd3);
    wr(2'd0, 8'h0B);
    cyc(10); chk("R8 clock ignored", irq, 0);
    ext_pulse(); ext_pulse();
    chk("R8 after two edges", irq, 0);
    ext_count_in = 1'b1; cyc(2); chk("R8 sync delay", irq, 0);
    cyc(1); chk("R8 third edge", irq, 1);
    cyc(6); ext_count_in = 1'b0; cyc(3);
    rd(2'd0, rv); chk("R8 level counts once", irq, 0);
    wr(2'd0, 8'h01);
  endtask

  task automatic t_zero();
    set_val(16'd0);
    wr(2'd0, 8'h03);
    cyc(65535); chk("R10 before 65536", irq, 0);
    cyc(1);     chk("R10 at 65536", irq, 1);
    wr(2'd0, 8'h01);
    rd(2'd0, rv);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset_reserved();
    t_byte_order();
    t_retrigger();
    t_collision();
    t_mask();
    t_oneshot();
    t_pause();
    t_external();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule